// File: doc/BRIEF.md
# Cascaded Audio Clock Divider

This block turns one of three free-running reference tick streams into the two clocks a serial audio link needs: a codec system clock (MCLK) and a bit clock (SCLK). All settings are taken from a 32-bit format word. A 2-bit field picks the reference stream. A 5-bit encoded ratio divides that stream down to MCLK, and a 4-bit encoded ratio divides MCLK further down to SCLK. A flag chooses whether SCLK is made here or follows an external pin.

Everything lives in one system clock domain. Each reference arrives as a one-cycle enable pulse. Every clock leaves the block in two forms: a one-cycle tick that marks the start of each output period, and a level that carries the duty cycle. Both forms are registered.

Top module: `audio_clkgen`

## Requirements
- R1: `fmt_word[31:30]` selects the reference stream: 0 picks `src_tick[0]`, 1 picks `src_tick[1]` and 2 picks `src_tick[2]`.
- R2: When `fmt_word[31:30]` is 3, no MCLK tick is produced, and in master mode no SCLK tick is produced either.
- R3: The MCLK ratio code `fmt_word[28:24]` has four special values: 0x14 divides by 1, 0x13 divides by 3, 0x12 divides by 5 and 0x0E divides by 14.
- R4: Any other MCLK code c divides by 2*(c+1), which covers 2 up to 64.
- R5: The SCLK ratio code `fmt_word[23:20]` divides the MCLK tick stream, not the reference. Code 8 divides by 1, code 9 divides by 3, and any other code c divides by 2*(c+1).
- R6: When `fmt_word[19]` is 1, SCLK comes from the internal divider. When it is 0, `sclk_o` follows `ext_sclk` one cycle late, and `sclk_en` pulses for one cycle in the cycle where `sclk_o` rises.
- R7: An output tick lasts one cycle and appears one cycle after the input tick that opens a period. The first input tick after reset or after a ratio change opens a period. For any ratio other than 1, ticks are never back to back.
- R8: In the first cycle in which a changed ratio code is seen, that divider clears its count, drives its level low and issues no tick, even if an input tick arrives in that cycle.
- R9: For a ratio N above 1, the level rises together with the tick and stays high for the first floor(N/2) input ticks of each period. It is low for the remaining ticks, so even ratios give 50% duty and ratios 3 and 5 are high one tick less than they are low.
- R10: For ratio 1, both the tick and the level equal the input tick delayed by one register.
- R11: While `rst_n` is low at a clock edge, all four clock outputs are low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_word | input | 32 | Format word holding the source, ratio and master fields |
| src_tick | input | 3 | One-cycle enables of the three reference streams |
| ext_sclk | input | 1 | External bit clock level, used in slave mode |
| mclk_en | output | 1 | MCLK period-start tick |
| mclk_o | output | 1 | MCLK level |
| sclk_en | output | 1 | SCLK period-start tick |
| sclk_o | output | 1 | SCLK level |

## Verification
The bench builds the block with its default parameters. These give MCLK counters sized for ratios up to 64 and SCLK counters sized for ratios up to 32, so the largest codes of both fields (0x1F and 15) can be reached. The bench drives the three reference streams at periods of 1, 2 and 3 cycles. Each expected period is therefore the product of the reference period and both ratios, and the duty checks cover ticks that arrive every cycle as well as sparse ticks where the level must hold between them.

// File: rtl/audio_clk_pkg.sv
package audio_clk_pkg;

    localparam int SEL_W   = 2;
    localparam int MCODE_W = 5;
    localparam int SCODE_W = 4;
    localparam int RATIO_W = 8;

    // Registered view of the external bit clock pin
    typedef struct packed {
        logic lvl;
        logic rise;
    } ext_state_t;

    // MCLK ratio: four special codes, otherwise an even ratio
    function automatic logic [RATIO_W-1:0] mclk_ratio(input logic [MCODE_W-1:0] c);
        logic [RATIO_W-1:0] r;
        case (c)
            5'h14:   r = 8'd1;
            5'h13:   r = 8'd3;
            5'h12:   r = 8'd5;
            5'h0E:   r = 8'd14;
            default: r = {2'b00, c, 1'b0} + 8'd2;
        endcase
        return r;
    endfunction

    // SCLK ratio: two special codes, otherwise an even ratio
    function automatic logic [RATIO_W-1:0] sclk_ratio(input logic [SCODE_W-1:0] c);
        logic [RATIO_W-1:0] r;
        case (c)
            4'h8:    r = 8'd1;
            4'h9:    r = 8'd3;
            default: r = {3'b000, c, 1'b0} + 8'd2;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/audio_src_select.sv
module audio_src_select
    import audio_clk_pkg::*;
#(
    parameter int NSRC = 3
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [NSRC-1:0]  src_tick,
    output logic             tick
);
    localparam int NSLOT = 1 << SEL_W;

    logic [NSLOT-1:0] slot;

    // Codes beyond the last source are tied off, so they stop the clocks
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        if (i < NSRC) begin : g_live
            assign slot[i] = src_tick[i];
        end else begin : g_off
            assign slot[i] = 1'b0;
        end
    end

    assign tick = slot[sel];
endmodule

// File: rtl/audio_tick_div.sv
module audio_tick_div
    import audio_clk_pkg::*;
#(
    parameter int CODE_W  = 5,
    parameter int MAX_DIV = 64,
    parameter bit IS_MCLK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic              in_tick,
    output logic              pulse_o,
    output logic              level_o
);
    localparam int CNT_W = $clog2(MAX_DIV);
    localparam int NW    = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] code;
        logic              pulse;
        logic              level;
    } div_state_t;

    div_state_t         st_d, st_q;
    logic [RATIO_W-1:0] ratio;
    logic [NW-1:0]      n, half, cnt_x;

    // The parameter picks which code table applies
    if (IS_MCLK) begin : g_mclk
        assign ratio = mclk_ratio(MCODE_W'(code));
    end else begin : g_sclk
        assign ratio = sclk_ratio(SCODE_W'(code));
    end

    assign n     = NW'(ratio);
    assign half  = n >> 1;
    assign cnt_x = NW'(st_q.cnt);

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (n == NW'(1)) begin
            st_d.level = 1'b0;
        end
        if (code != st_q.code) begin
            // Ratio changed: start clean, drop this cycle's tick
            st_d.code  = code;
            st_d.cnt   = '0;
            st_d.level = 1'b0;
        end else if (in_tick) begin
            st_d.pulse = (st_q.cnt == '0);
            st_d.level = (n == NW'(1)) ? 1'b1 : (cnt_x < half);
            st_d.cnt   = (cnt_x == n - NW'(1)) ? '0 : CNT_W'(cnt_x + NW'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.code <= code;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;
    assign level_o = st_q.level;
endmodule

// File: rtl/audio_sclk_route.sv
module audio_sclk_route
    import audio_clk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic master,
    input  logic int_pulse,
    input  logic int_level,
    input  logic ext_pin,
    output logic sclk_en,
    output logic sclk_o
);
    ext_state_t ext_d, ext_q;

    always_comb begin
        ext_d      = ext_q;
        ext_d.lvl  = ext_pin;
        ext_d.rise = ext_pin & ~ext_q.lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= '0;
        end else begin
            ext_q <= ext_d;
        end
    end

    assign sclk_en = master ? int_pulse : ext_q.rise;
    assign sclk_o  = master ? int_level : ext_q.lvl;
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import audio_clk_pkg::*;
#(
    parameter int NSRC     = 3,
    parameter int MCLK_MAX = 64,
    parameter int SCLK_MAX = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     fmt_word,
    input  logic [NSRC-1:0] src_tick,
    input  logic            ext_sclk,
    output logic            mclk_en,
    output logic            mclk_o,
    output logic            sclk_en,
    output logic            sclk_o
);
    localparam int SEL_LSB   = 30;
    localparam int MCODE_LSB = 24;
    localparam int SCODE_LSB = 20;
    localparam int MST_BIT   = 19;

    logic [SEL_W-1:0]   sel;
    logic [MCODE_W-1:0] mcode;
    logic [SCODE_W-1:0] scode;
    logic               master;
    logic               ref_tick;
    logic               s_pulse, s_level;
    logic               unused_fmt;

    assign sel        = fmt_word[SEL_LSB +: SEL_W];
    assign mcode      = fmt_word[MCODE_LSB +: MCODE_W];
    assign scode      = fmt_word[SCODE_LSB +: SCODE_W];
    assign master     = fmt_word[MST_BIT];
    assign unused_fmt = ^{fmt_word[29], fmt_word[18:0]};

    audio_src_select #(.NSRC(NSRC)) i_sel (
        .sel      (sel),
        .src_tick (src_tick),
        .tick     (ref_tick)
    );

    audio_tick_div #(.CODE_W(MCODE_W), .MAX_DIV(MCLK_MAX), .IS_MCLK(1'b1)) i_mdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .code    (mcode),
        .in_tick (ref_tick),
        .pulse_o (mclk_en),
        .level_o (mclk_o)
    );

    audio_tick_div #(.CODE_W(SCODE_W), .MAX_DIV(SCLK_MAX), .IS_MCLK(1'b0)) i_sdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .code    (scode),
        .in_tick (mclk_en),
        .pulse_o (s_pulse),
        .level_o (s_level)
    );

    audio_sclk_route i_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .master    (master),
        .int_pulse (s_pulse),
        .int_level (s_level),
        .ext_pin   (ext_sclk),
        .sclk_en   (sclk_en),
        .sclk_o    (sclk_o)
    );
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk
    import audio_clk_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] fmt_word,
    input logic        ext_sclk,
    input logic        mclk_en,
    input logic        mclk_o,
    input logic        sclk_en,
    input logic        sclk_o
);
    logic armed_q;
    logic ratio_one;

    always_ff @(posedge clk) begin
        armed_q <= rst_n;
    end

    assign ratio_one = (mclk_ratio(fmt_word[28:24]) == 8'd1);

    // R2: source code 3 yields no MCLK tick
    assert_src_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fmt_word[31:30]) == 2'd3) |-> !mclk_en);

    // R7: ratio above 1 never gives back-to-back ticks
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mclk_en && !ratio_one) |=> !mclk_en);

    // R10: ratio 1 makes level and tick identical
    assert_div1_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ratio_one) |-> (mclk_o == mclk_en));

    // R5: in master mode an SCLK tick follows an MCLK tick
    assert_cascade_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && fmt_word[19] && sclk_en) |-> $past(mclk_en));

    // R6: slave mode follows the pin one cycle late
    assert_slave_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !fmt_word[19]) |-> (sclk_o == $past(ext_sclk)));
endmodule

bind audio_clkgen audio_clkgen_chk i_chk (.*);

// File: tb/test_audio_clkgen.sv
module test_audio_clkgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fmt_word = '0;
    logic [2:0]  src_tick = '0;
    logic        ext_sclk = 1'b0;
    logic        mclk_en, mclk_o, sclk_en, sclk_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    audio_clkgen i_audio_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt_word (fmt_word),
        .src_tick (src_tick),
        .ext_sclk (ext_sclk),
        .mclk_en  (mclk_en),
        .mclk_o   (mclk_o),
        .sclk_en  (sclk_en),
        .sclk_o   (sclk_o)
    );

    // {sel, mclk code, sclk code}; expected ratios alongside
    localparam logic [10:0] VEC [8] = '{
        {2'd0, 5'h14, 4'd8}, {2'd1, 5'h13, 4'd9},
        {2'd2, 5'h12, 4'd0}, {2'd0, 5'h0E, 4'd1},
        {2'd1, 5'h00, 4'd15}, {2'd2, 5'h1F, 4'd2},
        {2'd0, 5'h15, 4'd7}, {2'd1, 5'h0D, 4'd10}
    };
    localparam int VNM [8] = '{1, 3, 5, 14, 2, 64, 44, 28};
    localparam int VNS [8] = '{1, 3, 2, 4, 32, 6, 16, 22};

    // Reference streams with periods 1, 2 and 3 cycles
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph == 5) ? 0 : ph + 1;
            src_tick = {(ph % 3) == 0, (ph % 2) == 0, 1'b1};
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] mk(input logic [1:0] s, input logic [4:0] m,
                                       input logic [3:0] b, input logic mst);
        return {s, 1'b0, m, b, mst, 19'd0};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic measure(input bit use_s, output int per, output int hi);
        int guard = 0;
        per = 0;
        hi  = 0;
        @(negedge clk);
        while (!(use_s ? sclk_en : mclk_en) && guard < 6000) begin
            @(negedge clk);
            guard++;
        end
        do begin
            hi  += int'(use_s ? sclk_o : mclk_o);
            per++;
            @(negedge clk);
        end while (!(use_s ? sclk_en : mclk_en) && per < 6000);
    endtask

    initial begin
        int per, hi;
        fmt_word = mk(2'd0, 5'h14, 4'd8, 1'b1);
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 mclk_en in reset", int'(mclk_en), 0);
        chk("R11 mclk_o in reset", int'(mclk_o), 0);
        chk("R11 sclk_en in reset", int'(sclk_en), 0);
        chk("R11 sclk_o in reset", int'(sclk_o), 0);
        rst_n = 1'b1;

        // Table walk: R1 R3 R4 R5 R9 R10
        for (int v = 0; v < 8; v++) begin
            int p, nm, ns, mp, mh, sp, sh;
            p  = int'(VEC[v][10:9]) + 1;
            nm = VNM[v];
            ns = VNS[v];
            mp = nm * p;
            mh = (nm == 1) ? 1 : (nm / 2) * p;
            sp = ns * mp;
            sh = (ns == 1) ? 1 : (ns / 2) * mp;
            fmt_word = mk(VEC[v][10:9], VEC[v][8:4], VEC[v][3:0], 1'b1);
            measure(1'b0, per, hi);
            chk($sformatf("R1/R3/R4 mclk period vec %0d", v), per, mp);
            chk($sformatf("R9/R10 mclk high vec %0d", v), hi, mh);
            measure(1'b1, per, hi);
            chk($sformatf("R5 sclk period vec %0d", v), per, sp);
            chk($sformatf("R9/R10 sclk high vec %0d", v), hi, sh);
        end

        // R2: source code 3 stops all ticks
        @(negedge clk);
        fmt_word = mk(2'd3, 5'h00, 4'd0, 1'b1);
        repeat (2) @(negedge clk);
        begin
            int seen_m = 0, seen_s = 0;
            for (int i = 0; i < 200; i++) begin
                seen_m += int'(mclk_en);
                seen_s += int'(sclk_en);
                @(negedge clk);
            end
            chk("R2 mclk ticks with source off", seen_m, 0);
            chk("R2 sclk ticks with source off", seen_s, 0);
        end

        // R7/R8: restart on ratio change, reference ticking every cycle
        fmt_word = mk(2'd0, 5'h0E, 4'd0, 1'b1);
        begin
            int guard = 0;
            @(negedge clk);
            while (!mclk_en && guard < 100) begin
                @(negedge clk);
                guard++;
            end
        end
        repeat (3) @(negedge clk);
        fmt_word = mk(2'd0, 5'h01, 4'd0, 1'b1);
        @(negedge clk);
        chk("R8 no tick in change cycle", int'(mclk_en), 0);
        chk("R8 level low in change cycle", int'(mclk_o), 0);
        @(negedge clk);
        chk("R7 tick on first tick after change", int'(mclk_en), 1);
        chk("R9 level rises with tick", int'(mclk_o), 1);
        @(negedge clk);
        chk("R7 tick lasts one cycle", int'(mclk_en), 0);
        chk("R9 level high second tick", int'(mclk_o), 1);
        @(negedge clk);
        chk("R9 level low third tick", int'(mclk_o), 0);
        @(negedge clk);
        chk("R9 level low fourth tick", int'(mclk_o), 0);
        chk("R7 no tick mid period", int'(mclk_en), 0);
        @(negedge clk);
        chk("R4 new period of 4", int'(mclk_en), 1);

        // R6: slave mode follows the pin
        fmt_word = mk(2'd0, 5'h14, 4'd8, 1'b0);
        repeat (2) @(negedge clk);
        chk("R6 slave idle level", int'(sclk_o), 0);
        ext_sclk = 1'b1;
        @(negedge clk);
        chk("R6 slave level follows pin", int'(sclk_o), 1);
        chk("R6 slave tick on rise", int'(sclk_en), 1);
        @(negedge clk);
        chk("R6 slave tick one cycle", int'(sclk_en), 0);
        chk("R6 slave level held", int'(sclk_o), 1);
        ext_sclk = 1'b0;
        @(negedge clk);
        chk("R6 slave level falls", int'(sclk_o), 0);
        chk("R6 no tick on fall", int'(sclk_en), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule